// File: doc/BRIEF.md
# Stack Pointer and Call/Return Sequencer

This block owns the stack of a small byte-oriented processor. The stack lives in the same byte-addressable RAM as program data and grows toward lower addresses. The block keeps the pointer and turns four commands into byte accesses on a single memory port: save a byte, restore a byte, enter a subroutine, and leave a subroutine. Entering a subroutine saves a return address that is several bytes wide and hands the jump target back to the program counter. Leaving a subroutine reads the saved bytes and hands the rebuilt address back.

Commands arrive on a valid/ready channel. A command is taken only on a cycle where `cmd_valid` and `cmd_ready` are both high. While a command is being worked, `cmd_ready` stays low. The source must then hold its command steady, and none of its fields has any effect. `cmd_ready` rises again in the cycle that `done` pulses, so a held command is taken on that same edge. Results are read in the `done` cycle and are not held for a consumer. The memory port follows a fixed rule: a write takes effect at the edge where `mem_req` and `mem_we` are high, and read data is returned on `mem_rdata` in the cycle after a read request. Address checking between stack and data regions is left to the software.

Top module: `stack_unit`

## Requirements
- R1: While reset is held and right after it is released, `sp_value` equals RAM_BYTES-1 (0x7FF by default), `sp_wrapped` is 0, `done` is 0, `busy` is 0 and `cmd_ready` is 1.
- R2: Save byte (`cmd_op` = 0) writes `cmd_byte` to the address held in the pointer, then lowers the pointer by one.
- R3: Restore byte (`cmd_op` = 1) first raises the pointer by one, then reads that address. The byte read appears on `pop_byte` in the `done` cycle. A save followed by a restore returns both the byte and the pointer to their earlier values.
- R4: Subroutine entry (`cmd_op` = 2) saves `cmd_pc`+1 one byte per write. The low byte goes to the pointer address and the next byte goes one address below it. The pointer drops by the byte count of the PC (2 by default). In the `done` cycle, `pc_load` is 1 and `pc_out` equals the `cmd_target` taken with the command.
- R5: Subroutine return (`cmd_op` = 3) reads the saved bytes back, most significant first. Each read raises the pointer by one before the access. In the `done` cycle, `pc_load` is 1 and `pc_out` holds the rebuilt address.
- R6: A command is taken only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low, and `busy` is high, from the cycle after acceptance until the `done` cycle. A command offered while `cmd_ready` is low changes no memory byte and does not change the pointer.
- R7: `done` is a one-cycle pulse. It comes 2 cycles after acceptance for a save, 3 for a restore, 3 for an entry and 5 for a return with the default 2-byte PC. `pc_load` is 0 on `done` of a save or restore.
- R8: There is at most one memory access per cycle. A read request is never issued in the cycle right after another read request.
- R9: Pointer arithmetic wraps modulo RAM_BYTES. Lowering from 0 gives RAM_BYTES-1, and raising from RAM_BYTES-1 gives 0. Every wrap sets `sp_wrapped`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 0 save byte, 1 restore byte, 2 enter subroutine, 3 return |
| cmd_byte | input | 8 | Byte to save |
| cmd_pc | input | 16 | Address of the calling instruction |
| cmd_target | input | 16 | Subroutine entry address |
| busy | output | 1 | A command is being worked |
| done | output | 1 | One-cycle completion pulse |
| pc_load | output | 1 | `pc_out` must be loaded into the program counter |
| pc_out | output | 16 | Jump target or restored return address |
| pop_byte | output | 8 | Byte restored by the last restore command |
| sp_value | output | 11 | Current stack pointer |
| sp_wrapped | output | 1 | Sticky pointer-wrap flag |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 11 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after a read request |

## Verification
Two events can fall in the same cycle. A command can finish, and the next command can be taken on that very edge. The bench provokes this by issuing a subroutine entry and then, while it is still busy, holding a save-byte command valid with a byte of its own. The bench checks three things: `cmd_ready` stays low in every busy cycle; the entry still reports its target; and the held byte lands one address below the two return-address bytes, with the pointer lowered by three in total. A second overlap happens when a pointer wrap coincides with a memory access at address 0 or the top address. A restore from the top address and a save at address 0 check both the wrapped addresses and the sticky flag.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR   = 3'd1,
    ST_RDI  = 3'd2,
    ST_RDC  = 3'd3,
    ST_FIN  = 3'd4
  } stk_state_e;
endpackage

// File: rtl/sp_counter.sv
module sp_counter #(
  parameter int RAM_BYTES = 2048,
  parameter int AW        = $clog2(RAM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_plus,
  output logic          wrapped
);
  localparam logic [AW-1:0] TOP  = AW'(RAM_BYTES - 1);
  localparam bit            POW2 = (RAM_BYTES & (RAM_BYTES - 1)) == 0;

  logic [AW-1:0] sp_minus;
  logic          at_top, at_zero;

  assign at_top  = (sp == TOP);
  assign at_zero = (sp == '0);

  generate
    if (POW2) begin : g_pow2
      // modulo wrap is free when the size fills the address width
      assign sp_plus  = sp + 1'b1;
      assign sp_minus = sp - 1'b1;
    end else begin : g_any
      assign sp_plus  = at_top  ? '0  : sp + 1'b1;
      assign sp_minus = at_zero ? TOP : sp - 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp      <= TOP;
      wrapped <= 1'b0;
    end else begin
      if (dec)      sp <= sp_minus;
      else if (inc) sp <= sp_plus;
      if ((dec && at_zero) || (inc && at_top)) wrapped <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_buf.sv
module frame_buf #(
  parameter int PC_W     = 16,
  parameter int PC_BYTES = PC_W / 8,
  parameter int CW       = (PC_BYTES > 1) ? $clog2(PC_BYTES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PC_W-1:0] load_val,
  input  logic [PC_W-1:0] tgt_in,
  input  logic            tgt_load,
  input  logic            shift_en,
  input  logic [7:0]      shift_in,
  input  logic [CW-1:0]   lane,
  output logic [7:0]      lane_byte,
  output logic [PC_W-1:0] value
);
  logic [PC_W-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      tgt_q <= '0;
    end else if (load) begin
      value <= load_val;
      tgt_q <= tgt_in;
    end else if (tgt_load) begin
      value <= tgt_q;
    end else if (shift_en) begin
      // most significant byte arrives first, so shift toward the top
      value <= (value << 8) | PC_W'(shift_in);
    end
  end

  always_comb begin
    lane_byte = '0;
    for (int i = 0; i < PC_BYTES; i++) begin
      if (lane == CW'(i)) lane_byte = value[8*i +: 8];
    end
  end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_pkg::*;
#(
  parameter int PC_BYTES = 2,
  parameter int CW       = (PC_BYTES > 1) ? $clog2(PC_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  output logic          cmd_ready,
  output logic          accept,
  output logic          wr_phase,
  output logic          rd_issue,
  output logic          rd_capt,
  output logic          tgt_load,
  output logic [CW-1:0] lane,
  output logic          done,
  output logic          pc_load
);
  stk_state_e state;
  stk_op_e    op_q;
  logic [CW-1:0] cnt;
  logic       single, last;

  assign single = (op_q == OP_PUSH) || (op_q == OP_POP);
  assign last   = single || (cnt == CW'(PC_BYTES - 1));
  assign lane   = cnt;

  assign cmd_ready = (state == ST_IDLE) || (state == ST_FIN);
  assign accept    = cmd_valid && cmd_ready;
  assign wr_phase  = (state == ST_WR);
  assign rd_issue  = (state == ST_RDI);
  assign rd_capt   = (state == ST_RDC);
  assign tgt_load  = wr_phase && last && (op_q == OP_CALL);
  assign done      = (state == ST_FIN);
  assign pc_load   = done && ((op_q == OP_CALL) || (op_q == OP_RET));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= OP_PUSH;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_FIN: begin
          if (accept) begin
            op_q  <= stk_op_e'(cmd_op);
            cnt   <= '0;
            state <= (stk_op_e'(cmd_op) == OP_PUSH || stk_op_e'(cmd_op) == OP_CALL)
                     ? ST_WR : ST_RDI;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_WR: begin
          if (last) state <= ST_FIN;
          else      cnt   <= cnt + 1'b1;
        end
        ST_RDI: state <= ST_RDC;
        ST_RDC: begin
          if (last) begin
            state <= ST_FIN;
          end else begin
            cnt   <= cnt + 1'b1;
            state <= ST_RDI;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_unit.sv
module stack_unit
  import stack_pkg::*;
#(
  parameter int RAM_BYTES = 2048,
  parameter int PC_W      = 16,
  parameter int AW        = $clog2(RAM_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [7:0]      cmd_byte,
  input  logic [PC_W-1:0] cmd_pc,
  input  logic [PC_W-1:0] cmd_target,
  output logic            busy,
  output logic            done,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_out,
  output logic [7:0]      pop_byte,
  output logic [AW-1:0]   sp_value,
  output logic            sp_wrapped,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata
);
  localparam int PC_BYTES = PC_W / 8;
  localparam int CW       = (PC_BYTES > 1) ? $clog2(PC_BYTES) : 1;

  logic          accept, wr_phase, rd_issue, rd_capt, tgt_load;
  logic [CW-1:0] lane;
  logic [AW-1:0] sp_plus;
  logic [PC_W-1:0] load_val, buf_val;

  stack_seq #(.PC_BYTES(PC_BYTES), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .accept(accept),
    .wr_phase(wr_phase), .rd_issue(rd_issue), .rd_capt(rd_capt),
    .tgt_load(tgt_load), .lane(lane),
    .done(done), .pc_load(pc_load)
  );

  sp_counter #(.RAM_BYTES(RAM_BYTES), .AW(AW)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .dec(wr_phase), .inc(rd_issue),
    .sp(sp_value), .sp_plus(sp_plus), .wrapped(sp_wrapped)
  );

  // entry saves the address after the calling instruction
  assign load_val = (stk_op_e'(cmd_op) == OP_CALL) ? cmd_pc + 1'b1 : PC_W'(cmd_byte);

  frame_buf #(.PC_W(PC_W), .PC_BYTES(PC_BYTES), .CW(CW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_val(load_val), .tgt_in(cmd_target),
    .tgt_load(tgt_load), .shift_en(rd_capt), .shift_in(mem_rdata),
    .lane(lane), .lane_byte(mem_wdata), .value(buf_val)
  );

  assign busy     = !cmd_ready;
  assign mem_req  = wr_phase || rd_issue;
  assign mem_we   = wr_phase;
  assign mem_addr = rd_issue ? sp_plus : sp_value;
  assign pc_out   = buf_val;
  assign pop_byte = buf_val[7:0];
endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk #(
  parameter int RAM_BYTES = 2048,
  parameter int AW        = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          done,
  input logic          pc_load,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] sp_value,
  input logic          sp_wrapped
);
  // R2
  write_at_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == sp_value));

  // R9
  write_lowers_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> (sp_value == (($past(sp_value) == '0) ?
                                           AW'(RAM_BYTES - 1) : $past(sp_value) - 1'b1)));

  // R3
  read_moves_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (sp_value == $past(mem_addr)));

  // R8
  read_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_req);

  // R6
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  load_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> done);

  // R9
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wrapped |=> sp_wrapped);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req);
endmodule

bind stack_unit stack_unit_chk #(.RAM_BYTES(RAM_BYTES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done(done), .pc_load(pc_load), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .sp_value(sp_value), .sp_wrapped(sp_wrapped)
);

// File: tb/stack_unit_test.sv
module stack_unit_test;
  localparam int RAM_BYTES = 2048;
  localparam int AW        = 11;
  localparam int PC_W      = 16;
  localparam int LIMIT     = 150000;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  din;
    logic [15:0] pc;
    logic [15:0] tgt;
    logic [10:0] sp;
    logic [15:0] res;
    logic [3:0]  lat;
  } vec_t;

  // op: 0 save, 1 restore, 2 enter, 3 return
  localparam vec_t VECS [8] = '{
    '{2'd0, 8'hA5, 16'h0000, 16'h0000, 11'h7FE, 16'h0000, 4'd2},
    '{2'd0, 8'h3C, 16'h0000, 16'h0000, 11'h7FD, 16'h0000, 4'd2},
    '{2'd1, 8'h00, 16'h0000, 16'h0000, 11'h7FE, 16'h003C, 4'd3},
    '{2'd2, 8'h00, 16'h1234, 16'h0456, 11'h7FC, 16'h0456, 4'd3},
    '{2'd0, 8'h77, 16'h0000, 16'h0000, 11'h7FB, 16'h0000, 4'd2},
    '{2'd1, 8'h00, 16'h0000, 16'h0000, 11'h7FC, 16'h0077, 4'd3},
    '{2'd3, 8'h00, 16'h0000, 16'h0000, 11'h7FE, 16'h1235, 4'd5},
    '{2'd1, 8'h00, 16'h0000, 16'h0000, 11'h7FF, 16'h00A5, 4'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [7:0] cmd_byte = '0;
  logic [PC_W-1:0] cmd_pc = '0, cmd_target = '0;
  logic cmd_ready, busy, done, pc_load, sp_wrapped;
  logic mem_req, mem_we;
  logic [PC_W-1:0] pc_out;
  logic [7:0] pop_byte, mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic [AW-1:0] sp_value, mem_addr;

  logic [7:0] ram [RAM_BYTES];
  int checks = 0, errors = 0, cyc = 0;
  int lat_seen;
  logic [PC_W-1:0] pc_seen;
  logic [7:0] byte_seen;
  logic load_seen;

  always #4 clk = ~clk;

  stack_unit #(.RAM_BYTES(RAM_BYTES), .PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_pc(cmd_pc), .cmd_target(cmd_target),
    .busy(busy), .done(done), .pc_load(pc_load), .pc_out(pc_out),
    .pop_byte(pop_byte), .sp_value(sp_value), .sp_wrapped(sp_wrapped),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // RAM model: write at the edge, read data one cycle later
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  always @(posedge clk) begin
    if (cyc > LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, LIMIT);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive one command at a negedge, wait for done, record what done shows
  task automatic run(input logic [1:0] op, input logic [7:0] din,
                     input logic [15:0] pc, input logic [15:0] tgt);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_byte = din; cmd_pc = pc; cmd_target = tgt;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat_seen = 1;
    while (!done) begin
      @(negedge clk);
      lat_seen++;
    end
    pc_seen = pc_out; byte_seen = pop_byte; load_seen = pc_load;
  endtask

  initial begin
    for (int i = 0; i < RAM_BYTES; i++) ram[i] = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 sp in reset", 32'(sp_value), 32'h7FF);
    check("R1 wrap in reset", 32'(sp_wrapped), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sp after reset", 32'(sp_value), 32'h7FF);
    check("R1 ready after reset", {29'd0, cmd_ready, busy, done}, 32'b100);

    // R2 R3 R4 R5 R7: table walk
    for (int v = 0; v < 8; v++) begin
      run(VECS[v].op, VECS[v].din, VECS[v].pc, VECS[v].tgt);
      check("R7 latency", 32'(lat_seen), 32'(VECS[v].lat));
      check("R2 R3 R4 R5 pointer", 32'(sp_value), 32'(VECS[v].sp));
      if (VECS[v].op == 2'd1) begin
        check("R3 restored byte", 32'(byte_seen), 32'(VECS[v].res));
        check("R7 no pc load on restore", 32'(load_seen), 32'd0);
      end else if (VECS[v].op[1]) begin
        check("R4 R5 pc out", 32'(pc_seen), 32'(VECS[v].res));
        check("R4 R5 pc load", 32'(load_seen), 32'd1);
      end else begin
        check("R7 no pc load on save", 32'(load_seen), 32'd0);
      end
      if (v == 3) begin
        check("R4 low byte at pointer", 32'(ram[11'h7FE]), 32'h35);
        check("R4 high byte below", 32'(ram[11'h7FD]), 32'h12);
      end
    end
    check("R2 first save kept", 32'(ram[11'h7FF]), 32'hA5);

    // R9: wrap both ways
    check("R9 no wrap yet", 32'(sp_wrapped), 32'd0);
    run(2'd1, 8'h00, 16'h0, 16'h0);
    check("R9 restore wraps to 0", 32'(sp_value), 32'h000);
    check("R9 restore read address 0", 32'(byte_seen), 32'h00);
    check("R9 wrap flag set", 32'(sp_wrapped), 32'd1);
    run(2'd0, 8'h5A, 16'h0, 16'h0);
    check("R9 save at 0 wraps to top", 32'(sp_value), 32'h7FF);
    check("R9 save wrote address 0", 32'(ram[0]), 32'h5A);
    run(2'd1, 8'h00, 16'h0, 16'h0);
    check("R9 wrapped restore byte", 32'(byte_seen), 32'h5A);
    check("R9 flag sticky", 32'(sp_wrapped), 32'd1);

    // R1 R9: reset clears pointer and flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 pointer back to top", 32'(sp_value), 32'h7FF);
    check("R9 flag cleared by reset", 32'(sp_wrapped), 32'd0);

    // R6 R7: held command while busy, taken on the done edge
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_pc = 16'h00FF; cmd_target = 16'h0200;
    @(negedge clk);
    cmd_op = 2'd0; cmd_byte = 8'h99; cmd_pc = 16'hFFFF; cmd_target = 16'hFFFF;
    while (!done) begin
      check("R6 ready low while busy", {30'd0, cmd_ready, busy}, 32'b01);
      @(negedge clk);
    end
    check("R4 entry target", 32'(pc_out), 32'h0200);
    check("R6 ready in done cycle", 32'(cmd_ready), 32'd1);
    check("R6 held command not acted on", 32'(sp_value), 32'h7FD);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat_seen = 1;
    while (!done) begin @(negedge clk); lat_seen++; end
    check("R7 held save latency", 32'(lat_seen), 32'd2);
    check("R4 carry into high byte", {16'd0, ram[11'h7FE], ram[11'h7FF]}, 32'h0100);
    check("R6 held byte below frame", 32'(ram[11'h7FD]), 32'h99);
    check("R6 pointer after both", 32'(sp_value), 32'h7FC);
    @(negedge clk);
    check("R7 done single cycle", 32'(done), 32'd0);
    check("R8 quiet when idle", 32'(mem_req), 32'd0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule